// File: doc/BRIEF.md
# Reloadable Pin Event Down-Counter

This block counts rising edges on an external input pin with an 8-bit down-counter and raises a one-cycle interrupt request each time the counter underflows. Software sets a reload value and a mode word through a small write port. The mode word holds a count-source select field, a load bit and a count-enable bit. A read port always shows the live count.

With a reload value N, one interrupt is produced for every N+1 counted edges. A reload value written while counting is running does not disturb the count in progress; it takes effect at the next underflow. Clearing the count-enable bit freezes the counter, and setting it again without a load resumes counting from the frozen value. The pin is brought into the clock domain by a two-flop synchronizer before edge detection.

Top module: `pin_event_counter`

## Requirements
- R1: After reset the count reads 0, the interrupt output is 0, the reload value is 0, and counting is disabled with the pin source deselected.
- R2: A write with `wrAddr`=0 stores `wrData` as the reload value. A write with `wrAddr`=1 stores the mode word: bits [2:0] select the source (3'b011 selects the pin), bit 3 is the load bit and bit 4 is the count-enable bit.
- R3: While the load bit is 1, the count takes the reload value on every cycle. No edge decrements it and no interrupt is raised.
- R4: With count-enable 1, source 3'b011 and load 0, each rising pin edge decrements the count by one. The new count is visible three clock edges after the first edge that samples the pin high.
- R5: A counted edge that arrives while the count is 0 reloads the count from the reload value and raises an interrupt, so reload value N gives one interrupt per N+1 edges.
- R6: Writing the reload value during counting leaves the current count unchanged. The new value is used at the next underflow.
- R7: With count-enable 0, pin edges leave the count unchanged. Setting count-enable to 1 again without a load resumes counting from the held value.
- R8: With any source encoding other than 3'b011, pin edges leave the count unchanged.
- R9: The interrupt output is high for exactly one clock cycle per underflow.
- R10: A pin held high for many cycles counts as a single edge, and falling edges are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 1 | Asynchronous event pin |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Register select: 0 reload value, 1 mode word |
| wrData | input | 8 | Write data |
| rdCount | output | 8 | Current count |
| irqPulse | output | 1 | One-cycle underflow interrupt request |

## Verification
A corrupted count shows directly on `rdCount` at the next sampled point after an edge. It also shifts every later underflow, so the running interrupt total drifts from the model within at most N+1 edges. A wrong reload path, for example one that takes the base value immediately rather than at underflow, shows up at the first underflow after a mid-run base write. A stuck or doubled interrupt shows up as a wrong total or as a pulse wider than one cycle.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic load;  // copy reload value into counter this cycle
    logic dec;   // one qualified pin edge to count this cycle
  } strobe_t;
endpackage

// File: rtl/evcnt_ctrl.sv
module evcnt_ctrl #(
  parameter int W       = 8,
  parameter int SRC_W   = 3,
  parameter int SRC_PIN = 3,
  parameter int SYNC_N  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pinIn,
  input  logic                 wrEn,
  input  logic                 wrAddr,
  input  logic [W-1:0]         wrData,
  output logic [W-1:0]         baseVal,
  output evcnt_pkg::strobe_t   strb
);
  localparam int LOAD_BIT = SRC_W;
  localparam int CEN_BIT  = SRC_W + 1;

  logic [SRC_W-1:0]  srcSel;
  logic              loadEn;
  logic              cntEn;
  logic [SYNC_N-1:0] syncQ;
  logic              prevQ;
  logic              riseEdge;
  logic              srcIsPin;

  // register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseVal <= '0;
      srcSel  <= '0;
      loadEn  <= 1'b0;
      cntEn   <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr == 1'b0) begin
        baseVal <= wrData;
      end else begin
        srcSel <= wrData[SRC_W-1:0];
        loadEn <= wrData[LOAD_BIT];
        cntEn  <= wrData[CEN_BIT];
      end
    end
  end

  // synchronizer chain and edge history
  generate
    if (SYNC_N == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= pinIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_N-2:0], pinIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SYNC_N-1];
  end

  always_comb begin
    riseEdge  = syncQ[SYNC_N-1] & ~prevQ;
    srcIsPin  = (srcSel == SRC_W'(SRC_PIN));
    strb.load = loadEn;
    strb.dec  = riseEdge & cntEn & srcIsPin & ~loadEn;
  end

  // R3: load holds off any counting
  p_load_blocks_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !strb.dec);

  // R10: a qualified edge never lasts two cycles
  p_edge_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.dec |=> !strb.dec);

  // R2: reload value write lands next cycle
  p_base_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 1'b0) |=> baseVal == $past(wrData));

  // R8: non-pin source never produces a count strobe
  p_src_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    !srcIsPin |-> !strb.dec);
endmodule

// File: rtl/evcnt_dp.sv
module evcnt_dp #(
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  evcnt_pkg::strobe_t strb,
  input  logic [W-1:0]       baseVal,
  output logic [W-1:0]       count,
  output logic               irq
);
  logic atZero;
  logic underflow;

  always_comb begin
    atZero    = (count == '0);
    underflow = strb.dec & atZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= underflow;
      if (strb.load || underflow) count <= baseVal;
      else if (strb.dec)          count <= count - 1'b1;
    end
  end

  // R3: load copies reload value
  p_load_copies_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> count == $past(baseVal));

  // R4: plain decrement
  p_dec_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dec && !atZero) |=> count == $past(count) - 1'b1);

  // R5: interrupt only after a zero-count edge, with reload
  p_irq_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dec && atZero) |=> (irq && count == $past(baseVal)));

  // R7: no strobe means count holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.dec && !strb.load) |=> $stable(count));

  // R9: single-cycle interrupt
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
endmodule

// File: rtl/pin_event_counter.sv
module pin_event_counter #(
  parameter int W       = 8,
  parameter int SRC_W   = 3,
  parameter int SRC_PIN = 3,
  parameter int SYNC_N  = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pinIn,
  input  logic         wrEn,
  input  logic         wrAddr,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdCount,
  output logic         irqPulse
);
  evcnt_pkg::strobe_t strb;
  logic [W-1:0]       baseVal;

  evcnt_ctrl #(.W(W), .SRC_W(SRC_W), .SRC_PIN(SRC_PIN), .SYNC_N(SYNC_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .baseVal(baseVal), .strb(strb)
  );

  evcnt_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .baseVal(baseVal),
    .count(rdCount), .irq(irqPulse)
  );

  // R1: quiet out of reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (rdCount == '0 && !irqPulse));
endmodule

// File: tb/pin_event_counter_bench.sv
module pin_event_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] PIN_SRC = 3'd3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pinIn = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrAddr = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdCount;
  logic       irqPulse;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // model state
  logic [7:0] mBase = 0, mCount = 0;
  logic [2:0] mSrc = 0;
  bit mLoad = 0, mCen = 0;
  int mIrqs = 0;
  int seenIrqs = 0;
  int wideIrq = 0;
  logic lastIrq = 1'b0;

  pin_event_counter u_pin_event_counter (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdCount(rdCount), .irqPulse(irqPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rstN) begin
      if (irqPulse) seenIrqs++;
      if (irqPulse && lastIrq) wideIrq++;
      lastIrq = irqPulse;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stepCount(logic [7:0] c, logic [7:0] b);
    return (c == 0) ? b : c - 8'd1;
  endfunction

  task automatic writeReg(logic a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setBase(logic [7:0] b);
    writeReg(1'b0, b);
    mBase = b;
  endtask

  task automatic setMode(logic [2:0] src, bit ld, bit cen);
    writeReg(1'b1, {3'b000, cen, ld, src});
    mSrc = src; mLoad = ld; mCen = cen;
    repeat (2) @(negedge clk);
    if (ld) mCount = mBase;
  endtask

  task automatic pulse(int hi, int lo);
    @(negedge clk);
    pinIn = 1'b1;
    repeat (hi) @(negedge clk);
    pinIn = 1'b0;
    repeat (lo) @(negedge clk);
    if (mCen && mSrc == PIN_SRC && !mLoad) begin
      if (mCount == 0) mIrqs++;
      mCount = stepCount(mCount, mBase);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 count", rdCount, 0);
    check("R1 irq", irqPulse, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    pulse(2, 4);
    check("R1 disabled after reset", rdCount, 0);

    // load and a full period
    setBase(8'd3);
    setMode(PIN_SRC, 1'b1, 1'b0);
    check("R3 load copies base", rdCount, 3);
    setMode(PIN_SRC, 1'b0, 1'b1);
    pulse(1, 3);
    check("R4 first decrement", rdCount, 2);
    pulse(2, 3); pulse(3, 3);
    check("R4 reached zero", rdCount, 0);
    check("R5 no irq before underflow", seenIrqs, 0);
    pulse(1, 4);
    check("R5 reload on underflow", rdCount, 3);
    check("R5 one irq per N+1 edges", seenIrqs, 1);

    // load held while enabled
    setMode(PIN_SRC, 1'b1, 1'b1);
    pulse(2, 3); pulse(2, 3);
    check("R3 no count during load", rdCount, 3);
    check("R3 no irq during load", seenIrqs, 1);
    setMode(PIN_SRC, 1'b0, 1'b1);

    // deferred base
    pulse(1, 3);
    setBase(8'd9);
    check("R6 base write keeps count", rdCount, 2);
    pulse(1, 3); pulse(1, 3); pulse(1, 3);
    check("R6 new base used at underflow", rdCount, 9);
    check("R6 irq count", seenIrqs, 2);

    // freeze and resume
    pulse(1, 3);
    setMode(PIN_SRC, 1'b0, 1'b0);
    pulse(1, 3); pulse(1, 3);
    check("R7 frozen", rdCount, 8);
    setMode(PIN_SRC, 1'b0, 1'b1);
    pulse(1, 3);
    check("R7 resume from held value", rdCount, 7);

    // other source
    setMode(3'd2, 1'b0, 1'b1);
    pulse(1, 3); pulse(1, 3);
    check("R8 non-pin source ignores pin", rdCount, 7);
    setMode(PIN_SRC, 1'b0, 1'b1);

    // long high level
    pulse(20, 4);
    check("R10 held level is one edge", rdCount, 6);

    // random phase
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = $urandom_range(0, 99);
      if (sel < 60) begin
        pulse($urandom_range(1, 4), $urandom_range(3, 5));
      end else if (sel < 70) begin
        setBase(8'($urandom_range(0, 6)));
      end else if (sel < 82) begin
        setMode(PIN_SRC, 1'b0, $urandom_range(0, 3) != 0);
      end else if (sel < 90) begin
        setMode(PIN_SRC, 1'b1, 1'b1);
        setMode(PIN_SRC, 1'b0, 1'b1);
      end else begin
        setMode(3'($urandom_range(0, 7)), 1'b0, 1'b1);
      end
      if (i % 20 == 0) begin
        check("R4 random count", rdCount, mCount);
        check("R5 random irq total", seenIrqs, mIrqs);
      end
    end
    check("R4 final count", rdCount, mCount);
    check("R5 final irq total", seenIrqs, mIrqs);
    check("R9 irq width one cycle", wideIrq, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule